// File: doc/BRIEF.md
# Write-Strobe Checking Burst Write Slave

This block is the write side of a memory-mapped slave that sits in front of a small word array. It accepts one write burst at a time on the address-write channel. It records the burst's ID, start address, beat count, beat size and burst kind, and then follows the beat address through the data beats. For each data beat, combinational logic works out which byte lanes that beat may drive and tests the byte-enable vector against them. Any enable bit outside the permitted lanes marks the beat as a violation.

A policy input is sampled when the address is accepted, and it chooses how violations are handled. In keep-legal mode, every legal beat is written into the array at once, one byte per set enable bit, and offending beats are dropped. In all-or-nothing mode, beats are held in a burst buffer and written only after the last beat, and only if no beat broke the rule. In both modes the write response reports slave error when any beat was illegal. A debug register holds the ID, beat address and enable value of the first violation until it is cleared, and a saturating counter counts offending bursts.

Top module: `wstrb_guard_slave`

## Requirements
- R1: Only one burst is in flight. aw_ready is high only when the block is idle. It drops on the cycle after an address handshake and stays low until the cycle after the response handshake. w_ready is high only between those two handshakes.
- R2: Permitted lanes for a beat start at lane (address mod 4) and end at the last lane of the beat's size-aligned container of 2^size bytes. A size above 2 permits no lane. An all-zero enable is always legal. Any set enable bit outside the permitted lanes is a violation.
- R3: Beat addresses advance as follows. Burst code 2'b01 (incrementing) moves to the next size-aligned address. Code 2'b10 (wrapping) wraps inside a window of (len+1)·2^size bytes. Code 2'b00 (fixed) keeps the start address.
- R4: b_resp is 2'b10 when any beat of the burst violated R2 and 2'b00 otherwise. b_id equals the burst's aw_id.
- R5: While b_valid is high and b_ready is low, b_valid, b_resp and b_id hold steady.
- R6: With policy_partial=1, each legal beat writes only the bytes whose enable bits are set, at its beat address. An illegal beat writes nothing.
- R7: With policy_partial=0, a burst that has any violation leaves the array untouched. A clean burst is written in full before its response appears.
- R8: policy_partial is sampled on the address handshake. Changing it later in the burst has no effect on that burst.
- R9: The first violation sets dbg_valid and records its ID, beat address and enable value. Later violations do not overwrite it. A dbg_clear pulse drops dbg_valid.
- R10: err_count rises by exactly one for each burst that has at least one violation, whatever the number of bad beats. It changes only on a last-beat handshake, saturates at all ones, and dbg_clear does not reset it.
- R11: After reset, aw_ready is 1, w_ready and b_valid are 0, dbg_valid is 0, err_count is 0 and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_partial | input | 1 | 1 = keep legal beats, 0 = drop whole offending burst |
| dbg_clear | input | 1 | Pulse to release the debug capture |
| aw_valid | input | 1 | Address-write valid |
| aw_ready | output | 1 | Address-write ready |
| aw_id | input | ID_W | Burst ID |
| aw_addr | input | ADDR_W | Byte start address |
| aw_len | input | LEN_W | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Write-data valid |
| w_ready | output | 1 | Write-data ready |
| w_data | input | DATA_W | Beat data |
| w_strb | input | DATA_W/8 | Byte enables |
| w_last | input | 1 | Final beat of burst |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | output | ID_W | Response ID |
| b_resp | output | 2 | 00 okay, 10 slave error |
| mem_rd_idx | input | log2(MEM_WORDS) | Array word to read |
| mem_rd_data | output | DATA_W | Combinational array word |
| dbg_valid | output | 1 | Debug capture holds a violation |
| dbg_id | output | ID_W | ID of captured violation |
| dbg_addr | output | ADDR_W | Beat address of captured violation |
| dbg_strb | output | DATA_W/8 | Enable value of captured violation |
| err_count | output | CNT_W | Saturating count of offending bursts |

## Verification
The hardest case to reach from the ports is an offending beat in the middle of an all-or-nothing burst while the policy input changes after the address handshake. To reach it, the bench drives a halfword burst with two bad beats between legal ones and flips the policy pin right after the address handshake. It then checks that no word changed, that the counter moved by exactly one, and that the debug capture points to the first bad beat. Counter saturation needs about 250 offending bursts in a row, so the bench ends with a loop of oversized-beat bursts before it checks the counter value.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_RESP   = 2'd3
    } wsg_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] BURST_WRAP  = 2'b10;
endpackage

// File: rtl/wsg_lane_check.sv
module wsg_lane_check #(
    parameter int BYTES  = 4,
    parameter int LANE_W = 2
) (
    input  logic [LANE_W-1:0] lo,
    input  logic [2:0]        size,
    input  logic [BYTES-1:0]  strb,
    output logic [BYTES-1:0]  allowed,
    output logic              violation
);
    logic [LANE_W:0] span;
    logic [LANE_W:0] base;

    always_comb begin
        allowed = '0;
        span    = '0;
        base    = '0;
        if (size <= 3'(LANE_W)) begin
            span = (LANE_W+1)'(1) << size;
            base = {1'b0, lo} & ~(span - 1'b1);
            for (int i = 0; i < BYTES; i++) begin
                allowed[i] = (i >= int'(lo)) && (i < int'(base + span));
            end
        end
        violation = |(strb & ~allowed);
    end
endmodule

// File: rtl/wsg_beat_buf.sv
module wsg_beat_buf #(
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 4,
    parameter int WIDX_W = 4,
    parameter int DATA_W = 32,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WIDX_W-1:0] wr_widx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_strb,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WIDX_W-1:0] rd_widx,
    output logic [DATA_W-1:0] rd_data,
    output logic [BYTES-1:0]  rd_strb
);
    logic [WIDX_W-1:0] widx_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [BYTES-1:0]  strb_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            widx_mem[wr_ptr] <= wr_widx;
            data_mem[wr_ptr] <= wr_data;
            strb_mem[wr_ptr] <= wr_strb;
        end
    end

    assign rd_widx = widx_mem[rd_ptr];
    assign rd_data = data_mem[rd_ptr];
    assign rd_strb = strb_mem[rd_ptr];
endmodule

// File: rtl/wsg_byte_mem.sv
module wsg_byte_mem #(
    parameter int WORDS  = 16,
    parameter int WIDX_W = 4,
    parameter int DATA_W = 32,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  wstrb,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wstrb[b]) begin
                    mem_q[widx][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/wstrb_guard_slave.sv
module wstrb_guard_slave
    import wsg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 16,
    parameter int MAX_BEATS = 16,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 8,
    localparam int BYTES    = DATA_W / 8,
    localparam int LANE_W   = $clog2(BYTES),
    localparam int WIDX_W   = $clog2(MEM_WORDS),
    localparam int ADDR_W   = WIDX_W + LANE_W,
    localparam int LEN_W    = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_partial,
    input  logic              dbg_clear,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [BYTES-1:0]  w_strb,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    input  logic [WIDX_W-1:0] mem_rd_idx,
    output logic [DATA_W-1:0] mem_rd_data,
    output logic              dbg_valid,
    output logic [ID_W-1:0]   dbg_id,
    output logic [ADDR_W-1:0] dbg_addr,
    output logic [BYTES-1:0]  dbg_strb,
    output logic [CNT_W-1:0]  err_count
);
    typedef struct packed {
        wsg_state_e        st;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [1:0]        burst;
        logic [LEN_W-1:0]  len;
        logic              partial;
        logic              err;
        logic [LEN_W-1:0]  beats;
        logic [LEN_W-1:0]  cptr;
        logic              dbg_vld;
        logic [ID_W-1:0]   dbg_id;
        logic [ADDR_W-1:0] dbg_addr;
        logic [BYTES-1:0]  dbg_strb;
        logic [CNT_W-1:0]  ecnt;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        st: ST_IDLE, id: '0, addr: '0, size: '0, burst: '0, len: '0,
        partial: 1'b0, err: 1'b0, beats: '0, cptr: '0, dbg_vld: 1'b0,
        dbg_id: '0, dbg_addr: '0, dbg_strb: '0, ecnt: '0
    };

    regs_t r_q, r_d;

    // Lane legality of the live beat
    logic [BYTES-1:0] lanes_ok;
    logic             beat_bad;

    wsg_lane_check #(.BYTES(BYTES), .LANE_W(LANE_W)) u_lane (
        .lo        (r_q.addr[LANE_W-1:0]),
        .size      (r_q.size),
        .strb      (w_strb),
        .allowed   (lanes_ok),
        .violation (beat_bad)
    );

    // Beat address sequencing
    logic [ADDR_W:0]   step, wrap_span, wrap_msk;
    logic [ADDR_W-1:0] aligned, incr_addr, next_addr;

    always_comb begin
        step      = (ADDR_W+1)'(1) << r_q.size;
        aligned   = r_q.addr & ~ADDR_W'(step - 1'b1);
        incr_addr = aligned + ADDR_W'(step);
        wrap_span = ((ADDR_W+1)'(r_q.len) + 1'b1) << r_q.size;
        wrap_msk  = wrap_span - 1'b1;
        case (r_q.burst)
            BURST_FIXED: next_addr = r_q.addr;
            BURST_WRAP:  next_addr = (r_q.addr & ~ADDR_W'(wrap_msk)) |
                                     (incr_addr & ADDR_W'(wrap_msk));
            default:     next_addr = incr_addr;
        endcase
    end

    // Burst buffer for all-or-nothing mode
    logic              buf_we;
    logic [WIDX_W-1:0] buf_widx;
    logic [DATA_W-1:0] buf_data;
    logic [BYTES-1:0]  buf_strb;

    wsg_beat_buf #(
        .DEPTH(MAX_BEATS), .PTR_W(LEN_W), .WIDX_W(WIDX_W),
        .DATA_W(DATA_W), .BYTES(BYTES)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_ptr  (r_q.beats),
        .wr_widx (r_q.addr[ADDR_W-1:LANE_W]),
        .wr_data (w_data),
        .wr_strb (w_strb),
        .rd_ptr  (r_q.cptr),
        .rd_widx (buf_widx),
        .rd_data (buf_data),
        .rd_strb (buf_strb)
    );

    // Array write port
    logic              mem_we;
    logic [WIDX_W-1:0] mem_widx;
    logic [DATA_W-1:0] mem_wdata;
    logic [BYTES-1:0]  mem_wstrb;

    wsg_byte_mem #(
        .WORDS(MEM_WORDS), .WIDX_W(WIDX_W), .DATA_W(DATA_W), .BYTES(BYTES)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .widx    (mem_widx),
        .wdata   (mem_wdata),
        .wstrb   (mem_wstrb),
        .rd_idx  (mem_rd_idx),
        .rd_data (mem_rd_data)
    );

    logic err_now;

    always_comb begin
        r_d       = r_q;
        buf_we    = 1'b0;
        mem_we    = 1'b0;
        mem_widx  = r_q.addr[ADDR_W-1:LANE_W];
        mem_wdata = w_data;
        mem_wstrb = w_strb;
        err_now   = r_q.err;

        if (dbg_clear) begin
            r_d.dbg_vld = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (aw_valid) begin
                    r_d.st      = ST_DATA;
                    r_d.id      = aw_id;
                    r_d.addr    = aw_addr;
                    r_d.size    = aw_size;
                    r_d.burst   = aw_burst;
                    r_d.len     = aw_len;
                    r_d.partial = policy_partial;
                    r_d.err     = 1'b0;
                    r_d.beats   = '0;
                end
            end
            ST_DATA: begin
                if (w_valid) begin
                    err_now = r_q.err | beat_bad;
                    r_d.err = err_now;
                    if (beat_bad && !r_d.dbg_vld) begin
                        r_d.dbg_vld  = 1'b1;
                        r_d.dbg_id   = r_q.id;
                        r_d.dbg_addr = r_q.addr;
                        r_d.dbg_strb = w_strb;
                    end
                    if (r_q.partial) begin
                        mem_we = !beat_bad;
                    end else begin
                        buf_we = 1'b1;
                    end
                    r_d.addr = next_addr;
                    if (w_last) begin
                        if (err_now && (r_q.ecnt != '1)) begin
                            r_d.ecnt = r_q.ecnt + 1'b1;
                        end
                        if (!r_q.partial && !err_now) begin
                            r_d.st   = ST_COMMIT;
                            r_d.cptr = '0;
                        end else begin
                            r_d.st = ST_RESP;
                        end
                    end else begin
                        r_d.beats = r_q.beats + 1'b1;
                    end
                end
            end
            ST_COMMIT: begin
                mem_we    = 1'b1;
                mem_widx  = buf_widx;
                mem_wdata = buf_data;
                mem_wstrb = buf_strb;
                r_d.cptr  = r_q.cptr + 1'b1;
                if (r_q.cptr == r_q.beats) begin
                    r_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (b_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign aw_ready  = (r_q.st == ST_IDLE);
    assign w_ready   = (r_q.st == ST_DATA);
    assign b_valid   = (r_q.st == ST_RESP);
    assign b_resp    = r_q.err ? RESP_SLVERR : RESP_OKAY;
    assign b_id      = r_q.id;
    assign dbg_valid = r_q.dbg_vld;
    assign dbg_id    = r_q.dbg_id;
    assign dbg_addr  = r_q.dbg_addr;
    assign dbg_strb  = r_q.dbg_strb;
    assign err_count = r_q.ecnt;
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_clear,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic              w_valid,
    input logic              w_ready,
    input logic              w_last,
    input logic              b_valid,
    input logic              b_ready,
    input logic [ID_W-1:0]   b_id,
    input logic [1:0]        b_resp,
    input logic              dbg_valid,
    input logic [ID_W-1:0]   dbg_id,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [BYTES-1:0]  dbg_strb,
    input logic [CNT_W-1:0]  err_count
);
    AST_AW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> !aw_ready); // R1
    AST_NO_AW_WITH_W: assert property (@(posedge clk) disable iff (!rst_n)
        w_ready |-> (!aw_ready && !b_valid)); // R1
    AST_NO_AW_WITH_B: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !aw_ready); // R1
    AST_RESP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp == 2'b00 || b_resp == 2'b10)); // R4
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp) && $stable(b_id))); // R5
    AST_DBG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid && !dbg_clear) |=>
        (dbg_valid && $stable(dbg_id) && $stable(dbg_addr) && $stable(dbg_strb))); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1)); // R10
    AST_CNT_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> $past(w_valid && w_ready && w_last)); // R10
endmodule

bind wstrb_guard_slave wsg_checker #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .BYTES(BYTES), .CNT_W(CNT_W)
) u_wsg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_clear (dbg_clear),
    .aw_valid  (aw_valid),
    .aw_ready  (aw_ready),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .w_last    (w_last),
    .b_valid   (b_valid),
    .b_ready   (b_ready),
    .b_id      (b_id),
    .b_resp    (b_resp),
    .dbg_valid (dbg_valid),
    .dbg_id    (dbg_id),
    .dbg_addr  (dbg_addr),
    .dbg_strb  (dbg_strb),
    .err_count (err_count)
);

// File: tb/wstrb_guard_slave_test.sv
`timescale 1ns/1ps
module wstrb_guard_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        policy_partial = 1'b0;
    logic        dbg_clear = 1'b0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [3:0]  aw_id = '0;
    logic [5:0]  aw_addr = '0;
    logic [3:0]  aw_len = '0;
    logic [2:0]  aw_size = '0;
    logic [1:0]  aw_burst = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        b_valid;
    logic        b_ready = 1'b0;
    logic [3:0]  b_id;
    logic [1:0]  b_resp;
    logic [3:0]  mem_rd_idx = '0;
    logic [31:0] mem_rd_data;
    logic        dbg_valid;
    logic [3:0]  dbg_id;
    logic [5:0]  dbg_addr;
    logic [3:0]  dbg_strb;
    logic [7:0]  err_count;

    always #2 clk = ~clk;

    wstrb_guard_slave uut (
        .clk(clk), .rst_n(rst_n), .policy_partial(policy_partial), .dbg_clear(dbg_clear),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .dbg_valid(dbg_valid), .dbg_id(dbg_id), .dbg_addr(dbg_addr), .dbg_strb(dbg_strb),
        .err_count(err_count)
    );

    // {addr mod 4, size, strobe, legal}
    localparam logic [9:0] VEC [18] = '{
        {2'd0, 3'd2, 4'hF, 1'b1}, {2'd0, 3'd2, 4'h0, 1'b1},
        {2'd1, 3'd2, 4'hE, 1'b1}, {2'd1, 3'd2, 4'hF, 1'b0},
        {2'd2, 3'd1, 4'hC, 1'b1}, {2'd2, 3'd1, 4'h4, 1'b1},
        {2'd2, 3'd1, 4'h3, 1'b0}, {2'd1, 3'd1, 4'h2, 1'b1},
        {2'd1, 3'd1, 4'h1, 1'b0}, {2'd1, 3'd1, 4'h6, 1'b0},
        {2'd3, 3'd0, 4'h8, 1'b1}, {2'd3, 3'd0, 4'hC, 1'b0},
        {2'd0, 3'd3, 4'h1, 1'b0}, {2'd0, 3'd3, 4'h0, 1'b1},
        {2'd2, 3'd2, 4'hC, 1'b1}, {2'd2, 3'd2, 4'hF, 1'b0},
        {2'd0, 3'd0, 4'h1, 1'b1}, {2'd0, 3'd0, 4'h2, 1'b0}
    };

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_mem [16];
    logic [31:0] bd [16];
    logic [3:0]  bs [16];
    logic [1:0]  got_resp;
    logic [3:0]  got_id;
    int          exp_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic model_write(input int w, input logic [31:0] d, input logic [3:0] s);
        for (int b = 0; b < 4; b++) begin
            if (s[b]) exp_mem[w][8*b +: 8] = d[8*b +: 8];
        end
    endtask

    task automatic check_mem(input string tag);
        logic [31:0] g, e;
        bit bad;
        g = '0; e = '0; bad = 1'b0;
        for (int w = 0; w < 16; w++) begin
            mem_rd_idx = 4'(w);
            #0.1;
            if (!bad && mem_rd_data !== exp_mem[w]) begin
                bad = 1'b1; g = mem_rd_data; e = exp_mem[w];
                $display("word %0d mismatch", w);
            end
        end
        chk(tag, g, e);
    endtask

    task automatic run_burst(input logic pol, input logic flip, input logic [3:0] id,
                             input logic [5:0] addr, input logic [3:0] len,
                             input logic [2:0] size, input logic [1:0] burst,
                             input int bdelay);
        logic [1:0] held;
        int wd;
        @(negedge clk);
        policy_partial = pol;
        aw_valid = 1'b1; aw_id = id; aw_addr = addr; aw_len = len;
        aw_size = size; aw_burst = burst;
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        if (flip) policy_partial = !pol;
        chk("R1 aw_ready low after accept", 32'(aw_ready), 32'd0);
        for (int k = 0; k <= int'(len); k++) begin
            w_valid = 1'b1; w_data = bd[k]; w_strb = bs[k]; w_last = (k == int'(len));
            @(posedge clk);
            @(negedge clk);
        end
        w_valid = 1'b0; w_last = 1'b0;
        wd = 0;
        while (!b_valid && wd < 100) begin
            @(negedge clk);
            wd++;
        end
        for (int k = 0; k < bdelay; k++) begin
            held = b_resp;
            @(negedge clk);
            chk("R5 b_valid held", 32'(b_valid), 32'd1);
            chk("R5 b_resp held", 32'(b_resp), 32'(held));
        end
        got_resp = b_resp; got_id = b_id;
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first_bad;
        for (int w = 0; w < 16; w++) exp_mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 aw_ready", 32'(aw_ready), 32'd1);
        chk("R11 w_ready", 32'(w_ready), 32'd0);
        chk("R11 b_valid", 32'(b_valid), 32'd0);
        chk("R11 dbg_valid", 32'(dbg_valid), 32'd0);
        chk("R11 err_count", 32'(err_count), 32'd0);
        check_mem("R11 array zero");

        // Table: single-beat lane checks, keep-legal mode (R2 R4 R6)
        first_bad = -1;
        for (int i = 0; i < 18; i++) begin
            logic [9:0] v;
            logic [5:0] a;
            v = VEC[i];
            a = {4'(i % 16), v[9:8]};
            bd[0] = 32'hC0DE0000 + 32'(i) * 32'h01010101;
            bs[0] = v[4:1];
            run_burst(1'b1, 1'b0, 4'(i), a, 4'd0, v[7:5], 2'b01, 0);
            chk("R4 table resp", 32'(got_resp), v[0] ? 32'd0 : 32'd2);
            chk("R4 table id", 32'(got_id), 32'(i % 16));
            if (v[0]) model_write(i % 16, bd[0], bs[0]);
            else begin
                exp_cnt++;
                if (first_bad < 0) first_bad = i;
            end
            check_mem("R2 R6 table array");
        end
        chk("R9 dbg_valid", 32'(dbg_valid), 32'd1);
        chk("R9 dbg_id", 32'(dbg_id), 32'(first_bad));
        chk("R9 dbg_addr", 32'(dbg_addr), 32'(first_bad * 4 + int'(VEC[first_bad][9:8])));
        chk("R9 dbg_strb", 32'(dbg_strb), 32'(VEC[first_bad][4:1]));
        chk("R10 count after table", 32'(err_count), 32'(exp_cnt));

        // R9 clear
        @(negedge clk); dbg_clear = 1'b1;
        @(negedge clk); dbg_clear = 1'b0;
        chk("R9 clear drops dbg_valid", 32'(dbg_valid), 32'd0);
        chk("R10 clear keeps count", 32'(err_count), 32'(exp_cnt));

        // R7 R3: clean all-or-nothing incrementing burst
        for (int k = 0; k < 4; k++) begin bd[k] = 32'hD0D0_0000 + 32'(k); bs[k] = 4'hF; end
        run_burst(1'b0, 1'b0, 4'd2, 6'h20, 4'd3, 3'd2, 2'b01, 0);
        for (int k = 0; k < 4; k++) model_write(8 + k, bd[k], 4'hF);
        chk("R4 clean resp", 32'(got_resp), 32'd0);
        chk("R4 clean id", 32'(got_id), 32'd2);
        check_mem("R7 clean burst written");

        // R7 R8 R10 R9: halfword burst, two bad beats, policy flipped after AW
        bd[0] = 32'hAAAA_1111; bd[1] = 32'hBBBB_2222; bd[2] = 32'hCCCC_3333; bd[3] = 32'hDDDD_4444;
        bs[0] = 4'h3; bs[1] = 4'hF; bs[2] = 4'hF; bs[3] = 4'hC;
        run_burst(1'b0, 1'b1, 4'd5, 6'h10, 4'd3, 3'd1, 2'b01, 0);
        exp_cnt++;
        chk("R4 reject resp", 32'(got_resp), 32'd2);
        check_mem("R7 R8 rejected burst leaves array");
        chk("R10 one per burst", 32'(err_count), 32'(exp_cnt));
        chk("R9 capture id", 32'(dbg_id), 32'd5);
        chk("R9 capture addr", 32'(dbg_addr), 32'h12);
        chk("R9 capture strb", 32'(dbg_strb), 32'hF);

        // R6: same burst in keep-legal mode
        bd[0] = 32'hE0E0_E0E0; bd[1] = 32'hE1E1_E1E1; bd[2] = 32'hE2E2_E2E2; bd[3] = 32'hE3E3_E3E3;
        run_burst(1'b1, 1'b0, 4'd6, 6'h10, 4'd3, 3'd1, 2'b01, 0);
        exp_cnt++;
        model_write(4, bd[0], 4'h3);
        model_write(5, bd[3], 4'hC);
        chk("R4 partial resp", 32'(got_resp), 32'd2);
        check_mem("R6 legal beats only");
        chk("R9 no overwrite", 32'(dbg_id), 32'd5);

        // R3 wrapping burst
        for (int k = 0; k < 4; k++) begin bd[k] = 32'hF000_0000 + 32'(k); bs[k] = 4'hF; end
        run_burst(1'b1, 1'b0, 4'd7, 6'h28, 4'd3, 3'd2, 2'b10, 0);
        model_write(10, bd[0], 4'hF); model_write(11, bd[1], 4'hF);
        model_write(8, bd[2], 4'hF);  model_write(9, bd[3], 4'hF);
        chk("R4 wrap resp", 32'(got_resp), 32'd0);
        check_mem("R3 wrap addresses");

        // R3 fixed burst with a bad third beat, response held (R5)
        bd[0] = 32'h0000_1100; bd[1] = 32'h0000_2200; bd[2] = 32'h0033_0000;
        bs[0] = 4'h2; bs[1] = 4'h2; bs[2] = 4'h4;
        run_burst(1'b1, 1'b0, 4'd9, 6'h31, 4'd2, 3'd0, 2'b00, 3);
        exp_cnt++;
        model_write(12, bd[0], 4'h2); model_write(12, bd[1], 4'h2);
        chk("R4 fixed resp", 32'(got_resp), 32'd2);
        chk("R4 fixed id", 32'(got_id), 32'd9);
        check_mem("R3 fixed address");

        // R2 R3 R7 unaligned first beat, clean all-or-nothing
        bd[0] = 32'h7766_5544; bd[1] = 32'h3322_1100; bs[0] = 4'hE; bs[1] = 4'hF;
        run_burst(1'b0, 1'b0, 4'd10, 6'h35, 4'd1, 3'd2, 2'b01, 0);
        model_write(13, bd[0], 4'hE); model_write(14, bd[1], 4'hF);
        chk("R2 unaligned resp", 32'(got_resp), 32'd0);
        check_mem("R2 R3 unaligned burst");

        // R10 saturation
        bd[0] = 32'hFFFF_FFFF; bs[0] = 4'h1;
        for (int n = 0; n < 250; n++) begin
            run_burst(1'b1, 1'b0, 4'd1, 6'h3C, 4'd0, 3'd3, 2'b01, 0);
            if (exp_cnt < 255) exp_cnt++;
        end
        chk("R10 saturates", 32'(err_count), 32'(exp_cnt));
        check_mem("R2 oversized beats not written");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule